// File: doc/BRIEF.md
# Protected SRAM Chip-Select Decoder

This block is glue logic between an 8/16-bit processor with a 24-bit address space and a 4 MB memory array. The array is built from eight 512 KB static RAMs. During the low half of the phase-2 clock the processor puts its upper address byte (the bank) on the data bus, and the block captures it. During the high half the block joins the held bank to the low 16 address bits to form the effective address. From that address it drives exactly one active-low chip select, plus a read enable and a qualified write strobe.

A window of the address map holds the kernel's interrupt handlers. By default the window runs from 0x00E000 to 0x00FFFF, and it is write-protected using the bus address alone. When protection is enabled, a write into the window keeps the write strobe inactive. It also drives the processor's active-low abort input, which stays asserted until phase-2 next falls. Reads from the window behave normally. With the protection-enable input held at 0, writes are allowed everywhere, so software can load the kernel at start-up.

All state is clocked by a fast system clock, and phase-2 is sampled as a level.

Top module: `prot_cs_decoder`

## Requirements
- R1: While `phi2` is 0, each clock edge loads `data_in` into the held bank. While `phi2` is 1, the bank is held, and the effective address is {bank, `addr_lo`} with bank as bits 23:16.
- R2: With `vda`=1, `phi2`=1 and effective bits 23:22 equal to 0, `cs_n[n]` is 0 exactly when effective bits 21:19 equal n. The other chip selects are 1, so at most one is 0 at any time.
- R3: Effective addresses with bits 23:22 nonzero (4 MB and above) drive all of `cs_n` to 1.
- R4: `rd_n` is 0 exactly when `vda`=1, `phi2`=1 and `rw_n`=1. `wd_n` is 0 exactly when `vda`=1, `phi2`=1 and `rw_n`=0, unless the write is blocked under R5.
- R5: A write (`rw_n`=0, `vda`=1, `phi2`=1) with `prot_en`=1 to an effective address in 0x00E000..0x00FFFF keeps `wd_n` at 1. Its chip select still follows R2.
- R6: After a blocked write under R5, `abort_n` is 0 from the next clock edge. It stays 0 for as long as `phi2` remains 1.
- R7: `abort_n` returns to 1 at the first clock edge that finds `phi2` at 0 after it was 1.
- R8: Reads from the protected window never drive `abort_n` to 0.
- R9: With `prot_en`=0, writes to the protected window assert `wd_n` as in R4, and `abort_n` stays 1.
- R10: With `vda`=0, no chip select, strobe or abort is asserted.
- R11: Synchronous reset `rst` clears the held bank to 0 and sets `abort_n` to 1. With `phi2`=0, all outputs are inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than phase-2 |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Processor phase-2 clock, sampled as a level |
| rw_n | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Valid address qualifier |
| prot_en | input | 1 | 1 enables write protection of the kernel window |
| data_in | input | 8 | Data bus, which carries the bank byte while phase-2 is low |
| addr_lo | input | 16 | Address bits 15:0 |
| cs_n | output | 8 | Active-low chip selects, one per 512 KB device |
| wd_n | output | 1 | Active-low qualified write strobe |
| rd_n | output | 1 | Active-low read enable |
| abort_n | output | 1 | Active-low abort request to the processor |

## Verification
The chip selects, `rd_n` and `wd_n` follow the inputs combinationally once the bank has been held. The bank itself takes one clock edge to load. `abort_n` falls one edge after a blocked write and rises one edge after `phi2` falls. Each bench bus cycle drives the bank for two edges and holds `phi2` high for two edges. It then samples all outputs at the falling clock edge after the second high-phase edge, where both the strobes and the abort are due. After one edge in the low phase it samples again, where the abort release and the inactive strobes are due.

// File: rtl/sramsel_pkg.sv
package sramsel_pkg;

    // address geometry
    localparam int ADDR_W     = 24;
    localparam int BANK_W     = 8;
    localparam int LOW_W      = ADDR_W - BANK_W;
    localparam int DEV_CNT    = 8;
    localparam int DEV_ADDR_W = 19;                     // 512 KB per device
    localparam int SEL_W      = $clog2(DEV_CNT);
    localparam int ARRAY_TOP  = DEV_ADDR_W + SEL_W;     // first bit above the array

    typedef logic [ADDR_W-1:0] ea_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        logic phi2;
        logic rw_n;
        logic vda;
    } bus_ctl_t;

    typedef enum logic {
        GUARD_CLEAR = 1'b0,
        GUARD_TRIP  = 1'b1
    } guard_st_e;

    localparam ea_t PROT_LO_DEF = 24'h00E000;
    localparam ea_t PROT_HI_DEF = 24'h00FFFF;

    function automatic logic in_window(ea_t a, ea_t lo, ea_t hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/bank_capture.sv
module bank_capture
    import sramsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  phi2,
    input  bank_t data_in,
    output bank_t bank_q
);
    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= '0;
        else if (!phi2)
            bank_q <= data_in;
    end
endmodule

// File: rtl/cs_decode.sv
module cs_decode
    import sramsel_pkg::*;
(
    input  logic                           vda,
    input  logic                           phi2,
    input  logic [ADDR_W-1:DEV_ADDR_W]     ea_hi,
    output logic [DEV_CNT-1:0]             cs_n
);
    logic             in_array;
    logic [SEL_W-1:0] sel;
    logic             qual;

    assign sel      = ea_hi[ARRAY_TOP-1:DEV_ADDR_W];
    assign in_array = (ea_hi[ADDR_W-1:ARRAY_TOP] == '0);
    assign qual     = vda & phi2 & in_array;

    for (genvar n = 0; n < DEV_CNT; n++) begin : g_dev
        assign cs_n[n] = ~(qual && (sel == SEL_W'(n)));
    end
endmodule

// File: rtl/write_guard.sv
module write_guard
    import sramsel_pkg::*;
#(
    parameter ea_t PROT_LO = PROT_LO_DEF,
    parameter ea_t PROT_HI = PROT_HI_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_ctl_t ctl,
    input  logic     prot_en,
    input  ea_t      ea,
    output logic     wd_n,
    output logic     rd_n,
    output logic     abort_n
);
    guard_st_e st_q;
    logic      phi2_q;
    logic      wr_cyc, rd_cyc, hit, violate, phi2_fall;

    assign wr_cyc    = ctl.vda & ctl.phi2 & ~ctl.rw_n;
    assign rd_cyc    = ctl.vda & ctl.phi2 &  ctl.rw_n;
    assign hit       = in_window(ea, PROT_LO, PROT_HI);
    assign violate   = wr_cyc & prot_en & hit;
    assign phi2_fall = phi2_q & ~ctl.phi2;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= GUARD_CLEAR;
            phi2_q <= 1'b0;
        end else begin
            phi2_q <= ctl.phi2;
            case (st_q)
                GUARD_CLEAR: if (violate)   st_q <= GUARD_TRIP;
                GUARD_TRIP:  if (phi2_fall) st_q <= GUARD_CLEAR;
                default:                    st_q <= GUARD_CLEAR;
            endcase
        end
    end

    assign wd_n    = ~(wr_cyc & ~violate);
    assign rd_n    = ~rd_cyc;
    assign abort_n = (st_q != GUARD_TRIP);
endmodule

// File: rtl/prot_cs_decoder.sv
module prot_cs_decoder
    import sramsel_pkg::*;
#(
    parameter ea_t PROT_LO = PROT_LO_DEF,
    parameter ea_t PROT_HI = PROT_HI_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               phi2,
    input  logic               rw_n,
    input  logic               vda,
    input  logic               prot_en,
    input  logic [BANK_W-1:0]  data_in,
    input  logic [LOW_W-1:0]   addr_lo,
    output logic [DEV_CNT-1:0] cs_n,
    output logic               wd_n,
    output logic               rd_n,
    output logic               abort_n
);
    bank_t    bank_q;
    ea_t      eff_addr;
    bus_ctl_t ctl;

    assign eff_addr = {bank_q, addr_lo};
    assign ctl      = '{phi2: phi2, rw_n: rw_n, vda: vda};

    bank_capture u_bank (
        .clk     (clk),
        .rst     (rst),
        .phi2    (phi2),
        .data_in (data_in),
        .bank_q  (bank_q)
    );

    cs_decode u_cs (
        .vda   (vda),
        .phi2  (phi2),
        .ea_hi (eff_addr[ADDR_W-1:DEV_ADDR_W]),
        .cs_n  (cs_n)
    );

    write_guard #(.PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .prot_en (prot_en),
        .ea      (eff_addr),
        .wd_n    (wd_n),
        .rd_n    (rd_n),
        .abort_n (abort_n)
    );
endmodule

// File: rtl/prot_cs_decoder_chk.sv
module prot_cs_decoder_chk
    import sramsel_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               phi2,
    input logic               rw_n,
    input logic               vda,
    input logic               prot_en,
    input logic [ADDR_W-1:0]  eff_addr,
    input logic [DEV_CNT-1:0] cs_n,
    input logic               wd_n,
    input logic               rd_n,
    input logic               abort_n
);
    logic kern_win;
    assign kern_win = (eff_addr[23:16] == 8'h00) && (eff_addr[15:13] == 3'b111);

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R3
    cs_high_range_chk: assert property (@(posedge clk) disable iff (rst)
        (eff_addr[23:22] != 2'b00) |-> (cs_n == '1));

    // R10
    no_valid_no_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!vda || !phi2) |-> (cs_n == '1 && wd_n && rd_n));

    // R4
    wd_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        !wd_n |-> (!rw_n && vda && phi2));

    // R5
    wd_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (prot_en && vda && phi2 && !rw_n && kern_win) |-> wd_n);

    // R6
    abort_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (prot_en && vda && phi2 && !rw_n && kern_win) |=> !abort_n);

    // R6
    abort_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!abort_n && phi2) |=> !abort_n);

    // R7
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(phi2) |=> abort_n);

    // R8
    abort_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(abort_n) |-> $past(!rw_n && prot_en && vda));
endmodule

bind prot_cs_decoder prot_cs_decoder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .phi2     (phi2),
    .rw_n     (rw_n),
    .vda      (vda),
    .prot_en  (prot_en),
    .eff_addr (eff_addr),
    .cs_n     (cs_n),
    .wd_n     (wd_n),
    .rd_n     (rd_n),
    .abort_n  (abort_n)
);

// File: tb/sim_prot_cs_decoder.sv
`timescale 1ns/1ps
module sim_prot_cs_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi2 = 1'b0, rw_n = 1'b1, vda = 1'b0, prot_en = 1'b1;
    logic [7:0]  data_in = '0;
    logic [15:0] addr_lo = '0;
    logic [7:0]  cs_n;
    logic        wd_n, rd_n, abort_n;

    always #10 clk = ~clk;

    prot_cs_decoder u0 (.*);

    typedef struct {
        logic [7:0] cs;
        logic       wd, rd, ab;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0, n_bad = 0;
    event samp_hi, samp_lo;
    bit   done = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected values from the requirements
    task automatic bus_cycle(logic [7:0] bank, logic [15:0] a, logic r, logic v,
                             logic en, string tag);
        exp_t e;
        logic [23:0] ea = {bank, a};
        logic prot = (bank == 8'h00) && (a >= 16'hE000);
        logic blk  = v && !r && en && prot;
        e.cs  = (!v || ea[23:22] != 2'b00) ? 8'hFF : ~(8'h01 << ea[21:19]);
        e.rd  = ~(v & r);
        e.wd  = ~(v & ~r & ~blk);
        e.ab  = ~blk;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk); #1 phi2 = 0; vda = 0; data_in = bank;
        @(negedge clk); @(negedge clk);
        #1 phi2 = 1; addr_lo = a; rw_n = r; vda = v; prot_en = en; data_in = 8'h00;
        @(negedge clk); @(negedge clk);
        -> samp_hi;
        #1 phi2 = 0; vda = 0; data_in = 8'hA5;
        @(negedge clk);
        -> samp_lo;
        #1;
    endtask

    initial begin : monitor
        exp_t c;
        forever begin
            @(samp_hi);
            c = q.pop_front();
            chk({c.tag, " cs_n"},    {24'h0, cs_n}, {24'h0, c.cs});
            chk({c.tag, " wd_n"},    {31'h0, wd_n}, {31'h0, c.wd});
            chk({c.tag, " rd_n"},    {31'h0, rd_n}, {31'h0, c.rd});
            chk({c.tag, " abort_n"}, {31'h0, abort_n}, {31'h0, c.ab});
            @(samp_lo);
            chk({c.tag, " R7 release/idle"}, {20'h0, cs_n, wd_n, rd_n, abort_n, 1'b0},
                {20'h0, 8'hFF, 3'b111, 1'b0});
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R11 reset state
        chk("R11 outputs after reset", {20'h0, cs_n, wd_n, rd_n, abort_n, 1'b0},
            {20'h0, 8'hFF, 3'b111, 1'b0});
        bus_cycle(8'h00, 16'h1234, 1, 1, 1, "R1 R2 R4 read dev0");
        bus_cycle(8'h08, 16'h0000, 0, 1, 1, "R1 R2 write dev1");
        bus_cycle(8'h3F, 16'hFFFF, 0, 1, 1, "R2 write dev7");
        bus_cycle(8'h20, 16'h4000, 1, 1, 1, "R1 R2 read dev4");
        bus_cycle(8'h40, 16'h0000, 0, 1, 1, "R3 above 4MB");
        bus_cycle(8'hC3, 16'h8000, 1, 1, 1, "R3 top bank read");
        bus_cycle(8'h00, 16'hE000, 0, 1, 1, "R5 R6 protected low edge");
        bus_cycle(8'h00, 16'hFFFF, 0, 1, 1, "R5 R6 protected high edge");
        bus_cycle(8'h00, 16'hDFFF, 0, 1, 1, "R5 just below window");
        bus_cycle(8'h01, 16'hE000, 0, 1, 1, "R5 other bank not protected");
        bus_cycle(8'h00, 16'hE800, 1, 1, 1, "R8 read protected");
        bus_cycle(8'h00, 16'hF000, 0, 1, 0, "R9 protection off");
        bus_cycle(8'h00, 16'hE000, 0, 0, 1, "R10 no valid address");
        bus_cycle(8'h00, 16'hFFFE, 0, 1, 1, "R6 abort again");
        bus_cycle(8'h10, 16'h0010, 0, 1, 1, "R7 write after abort");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        #(20 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule